// File: doc/BRIEF.md
# Load-Linked / Store-Conditional Reservation Monitor

This block sits beside one processor's memory port and gives it a lock-free way to do an atomic read-modify-write. A load-linked access reads memory as usual and also records a reservation: the address granule it touched and a valid bit. A later store-conditional to the same granule is allowed to write memory only while that reservation is still valid. The processor gets a one-bit result telling it whether the store took effect.

The reservation is lost in four ways. Another processor writes into the reserved granule, which the monitor sees on a snoop port. An interrupt arrives. A context switch is signalled. Any store-conditional is issued, whether it succeeds or fails. A new load-linked replaces whatever reservation was held before. Ordinary loads and stores pass straight through to memory and leave the reservation alone. Because of this, software retries the load-linked / store-conditional pair in a loop, and the bus never has to be locked between the read and the write.

Top module: `llsc_monitor`

## Requirements
- R1: A load-linked (req_op = 2'b10) sets the reservation to the granule of req_addr and returns mem_rdata on resp_rdata with resp_valid high in the cycle after the request.
- R2: A store-conditional (req_op = 2'b11) that holds a valid reservation for its granule asserts mem_we in the same cycle, with mem_addr = req_addr and mem_wdata = req_wdata.
- R3: Every request produces resp_valid one cycle later. For a store-conditional, resp_sc_ok is 1 on success and 0 on failure, and a failed store-conditional never asserts mem_we.
- R4: A snoop write (snoop_valid) whose address falls in the reserved granule clears the reservation.
- R5: irq or ctx_switch high in any cycle clears the reservation. In the same cycle it also makes a store-conditional fail and stops a load-linked from setting a reservation.
- R6: Any store-conditional clears the reservation, whether it succeeds or fails.
- R7: A store-conditional to a granule other than the reserved one fails and does not write memory.
- R8: A snoop write to the reserved granule in the same cycle as a store-conditional to it wins: the store-conditional fails.
- R9: A new load-linked replaces any earlier reservation, so a later store-conditional succeeds only for the newer granule.
- R10: Addresses match on bits [ADDR_W-1:GRAN_LSB] only. Differences below GRAN_LSB still match, and a snoop outside the granule leaves the reservation intact.
- R11: After reset no reservation is held and resp_valid is low. A plain store (2'b01) writes memory and a plain load (2'b00) reads it, and neither changes the reservation.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Local request present this cycle |
| req_op | input | 2 | 00 load, 01 store, 10 load-linked, 11 store-conditional |
| req_addr | input | ADDR_W | Request byte address |
| req_wdata | input | DATA_W | Store data |
| snoop_valid | input | 1 | Another processor writes this cycle |
| snoop_addr | input | ADDR_W | Address of that remote write |
| irq | input | 1 | Interrupt taken |
| ctx_switch | input | 1 | Context switch |
| mem_re | output | 1 | Memory read strobe (data returns next cycle) |
| mem_we | output | 1 | Memory write enable |
| mem_addr | output | ADDR_W | Memory address |
| mem_wdata | output | DATA_W | Memory write data |
| mem_rdata | input | DATA_W | Memory read data, one cycle after mem_re |
| resp_valid | output | 1 | Response for the previous cycle's request |
| resp_rdata | output | DATA_W | Load / load-linked data |
| resp_sc_ok | output | 1 | Store-conditional result |

## Verification
The bench aims at the same-cycle race between a snoop and a store-conditional. A design that let the local store win would report success and write over the remote update. It also checks that a failed store-conditional clears the reservation too. A monitor that kept the flag would let a retry succeed with no new load-linked. Granule matching is tested from both sides: a partial-word address inside the granule must match, and a snoop just outside it must not clear the reservation. A coarse or off-by-one comparator would show up as a spurious success or a spurious failure. Replacement by a second load-linked, and a plain store that must leave the reservation alone, catch designs that stack reservations or clear the flag on every write.

// File: rtl/llsc_monitor.sv
module llsc_monitor #(
  parameter int ADDR_W   = 32,
  parameter int DATA_W   = 32,
  parameter int GRAN_LSB = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic [1:0]        req_op,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  input  logic              snoop_valid,
  input  logic [ADDR_W-1:0] snoop_addr,
  input  logic              irq,
  input  logic              ctx_switch,
  output logic              mem_re,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [DATA_W-1:0] mem_wdata,
  input  logic [DATA_W-1:0] mem_rdata,
  output logic              resp_valid,
  output logic [DATA_W-1:0] resp_rdata,
  output logic              resp_sc_ok
);
  localparam logic [1:0] OP_LD = 2'b00;
  localparam logic [1:0] OP_ST = 2'b01;
  localparam logic [1:0] OP_LL = 2'b10;
  localparam logic [1:0] OP_SC = 2'b11;
  localparam logic [ADDR_W-1:0] GRAN_MASK = {ADDR_W{1'b1}} << GRAN_LSB;

  logic              rsv_q;
  logic [ADDR_W-1:0] rsv_tag_q;
  logic              resp_valid_q;
  logic              resp_ok_q;

  logic [ADDR_W-1:0] req_tag, snp_tag;
  logic is_ld, is_st, is_ll, is_sc;
  logic kill, snp_on_held, snp_on_new, sc_pass;

  assign req_tag = req_addr & GRAN_MASK;
  assign snp_tag = snoop_addr & GRAN_MASK;

  assign is_ld = req_valid && (req_op == OP_LD);
  assign is_st = req_valid && (req_op == OP_ST);
  assign is_ll = req_valid && (req_op == OP_LL);
  assign is_sc = req_valid && (req_op == OP_SC);

  assign kill        = irq || ctx_switch;
  assign snp_on_held = snoop_valid && (snp_tag == rsv_tag_q);
  assign snp_on_new  = snoop_valid && (snp_tag == req_tag);

  assign sc_pass = is_sc && rsv_q && (req_tag == rsv_tag_q) && !kill && !snp_on_held;

  assign mem_re    = is_ld || is_ll;
  assign mem_we    = is_st || sc_pass;
  assign mem_addr  = req_addr;
  assign mem_wdata = req_wdata;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsv_q     <= 1'b0;
      rsv_tag_q <= '0;
    end else if (kill) begin
      rsv_q <= 1'b0;
    end else if (is_ll) begin
      rsv_tag_q <= req_tag;
      rsv_q     <= !snp_on_new;
    end else if (is_sc || snp_on_held) begin
      rsv_q <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      resp_valid_q <= 1'b0;
      resp_ok_q    <= 1'b0;
    end else begin
      resp_valid_q <= req_valid;
      resp_ok_q    <= sc_pass;
    end
  end

  assign resp_valid = resp_valid_q;
  assign resp_sc_ok = resp_ok_q;
  assign resp_rdata = mem_rdata;

  AST_LL_RESERVES: assert property (@(posedge clk) disable iff (!rst_n)
    (is_ll && !kill && !snp_on_new) |=> (rsv_q && rsv_tag_q == ($past(req_addr) & GRAN_MASK))); // R1
  AST_SC_REPORTS: assert property (@(posedge clk) disable iff (!rst_n)
    is_sc |=> (resp_valid && resp_sc_ok == $past(mem_we))); // R3
  AST_SNOOP_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (snp_on_held && !is_ll) |=> !rsv_q); // R4
  AST_KILL_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    kill |=> !rsv_q); // R5
  AST_SC_CONSUMES: assert property (@(posedge clk) disable iff (!rst_n)
    is_sc |=> !rsv_q); // R6
  AST_SC_MISS_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    (is_sc && (req_tag != rsv_tag_q)) |-> !mem_we); // R7
  AST_SNOOP_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    (is_sc && snoop_valid && (snp_tag == req_tag)) |-> !mem_we); // R8
  AST_PLAIN_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
    ((is_ld || is_st) && !kill && !snp_on_held) |=> $stable(rsv_q)); // R11
endmodule

// File: tb/tb_llsc_monitor.sv
`timescale 1ns/1ps
module tb_llsc_monitor;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_valid = 1'b0;
  logic [1:0] req_op = 2'b00;
  logic [31:0] req_addr = '0, req_wdata = '0;
  logic snoop_valid = 1'b0;
  logic [31:0] snoop_addr = '0;
  logic irq = 1'b0, ctx_switch = 1'b0;
  logic mem_re, mem_we, resp_valid, resp_sc_ok;
  logic [31:0] mem_addr, mem_wdata, resp_rdata;
  logic [31:0] mem_rdata = '0;
  logic [31:0] mem [64];

  int checks = 0, errors = 0, cycles = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  llsc_monitor dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_op(req_op),
    .req_addr(req_addr), .req_wdata(req_wdata), .snoop_valid(snoop_valid),
    .snoop_addr(snoop_addr), .irq(irq), .ctx_switch(ctx_switch),
    .mem_re(mem_re), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_rdata(mem_rdata), .resp_valid(resp_valid), .resp_rdata(resp_rdata),
    .resp_sc_ok(resp_sc_ok)
  );

  always @(posedge clk) begin
    if (mem_we) mem[mem_addr[7:2]] <= mem_wdata;
    if (mem_re) mem_rdata <= mem[mem_addr[7:2]];
  end

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  endtask

  initial begin
    forever begin
      @(posedge clk);
      cycles++;
      if (cycles > 20000) begin
        errors++;
        checks++;
        $display("FAIL watchdog: actual=%0d expected<20000", cycles);
        finish_run();
      end
    end
  end

  task automatic do_op(input logic [1:0] op, input logic [31:0] a, input logic [31:0] d,
                       input logic sv, input logic [31:0] sa, input logic ir, input logic cs,
                       output logic we, output logic ok, output logic [31:0] rd, output logic rv);
    @(negedge clk);
    req_valid = 1; req_op = op; req_addr = a; req_wdata = d;
    snoop_valid = sv; snoop_addr = sa; irq = ir; ctx_switch = cs;
    #1 we = mem_we;
    @(negedge clk);
    ok = resp_sc_ok; rd = resp_rdata; rv = resp_valid;
    req_valid = 0; snoop_valid = 0; irq = 0; ctx_switch = 0;
  endtask

  task automatic event_only(input logic sv, input logic [31:0] sa, input logic ir, input logic cs);
    @(negedge clk);
    snoop_valid = sv; snoop_addr = sa; irq = ir; ctx_switch = cs;
    @(negedge clk);
    snoop_valid = 0; irq = 0; ctx_switch = 0;
  endtask

  logic we, ok, rv;
  logic [31:0] rd;

  task automatic t_reset();
    @(negedge clk);
    check("R11 resp_valid after reset", {31'b0, resp_valid}, 0);
    do_op(2'b11, 32'h10, 32'h55, 0, 0, 0, 0, we, ok, rd, rv);
    check("R11 SC after reset no write", {31'b0, we}, 0);
    check("R3 SC after reset fails", {31'b0, ok}, 0);
    check("R3 resp_valid", {31'b0, rv}, 1);
  endtask

  task automatic t_basic();
    do_op(2'b10, 32'h20, 0, 0, 0, 0, 0, we, ok, rd, rv);
    check("R1 LL data", rd, 32'h1008);
    check("R1 LL resp_valid", {31'b0, rv}, 1);
    do_op(2'b11, 32'h20, 32'hA5, 0, 0, 0, 0, we, ok, rd, rv);
    check("R2 SC write enable", {31'b0, we}, 1);
    check("R3 SC success", {31'b0, ok}, 1);
    do_op(2'b00, 32'h20, 0, 0, 0, 0, 0, we, ok, rd, rv);
    check("R2 SC data stored", rd, 32'hA5);
    do_op(2'b11, 32'h20, 32'hB6, 0, 0, 0, 0, we, ok, rd, rv);
    check("R6 second SC fails", {31'b0, ok}, 0);
    check("R6 second SC no write", {31'b0, we}, 0);
  endtask

  task automatic t_granule();
    do_op(2'b10, 32'h30, 0, 0, 0, 0, 0, we, ok, rd, rv);
    do_op(2'b11, 32'h33, 32'h1, 0, 0, 0, 0, we, ok, rd, rv);
    check("R10 same granule SC ok", {31'b0, ok}, 1);
    do_op(2'b10, 32'h50, 0, 0, 0, 0, 0, we, ok, rd, rv);
    event_only(1, 32'h54, 0, 0);
    do_op(2'b11, 32'h50, 32'h2, 0, 0, 0, 0, we, ok, rd, rv);
    check("R10 outside snoop keeps rsv", {31'b0, ok}, 1);
  endtask

  task automatic t_mismatch();
    do_op(2'b10, 32'h40, 0, 0, 0, 0, 0, we, ok, rd, rv);
    do_op(2'b11, 32'h44, 32'h3, 0, 0, 0, 0, we, ok, rd, rv);
    check("R7 mismatch no write", {31'b0, we}, 0);
    check("R7 mismatch fails", {31'b0, ok}, 0);
    do_op(2'b11, 32'h40, 32'h3, 0, 0, 0, 0, we, ok, rd, rv);
    check("R6 failed SC consumed rsv", {31'b0, ok}, 0);
  endtask

  task automatic t_snoop();
    do_op(2'b10, 32'h50, 0, 0, 0, 0, 0, we, ok, rd, rv);
    event_only(1, 32'h52, 0, 0);
    do_op(2'b11, 32'h50, 32'h4, 0, 0, 0, 0, we, ok, rd, rv);
    check("R4 snoop hit clears", {31'b0, ok}, 0);
    check("R4 snoop hit no write", {31'b0, we}, 0);
  endtask

  task automatic t_kill();
    do_op(2'b10, 32'h60, 0, 0, 0, 0, 0, we, ok, rd, rv);
    event_only(0, 0, 1, 0);
    do_op(2'b11, 32'h60, 32'h5, 0, 0, 0, 0, we, ok, rd, rv);
    check("R5 irq clears", {31'b0, ok}, 0);
    do_op(2'b10, 32'h60, 0, 0, 0, 0, 0, we, ok, rd, rv);
    event_only(0, 0, 0, 1);
    do_op(2'b11, 32'h60, 32'h5, 0, 0, 0, 0, we, ok, rd, rv);
    check("R5 ctx switch clears", {31'b0, ok}, 0);
    do_op(2'b10, 32'h60, 0, 0, 0, 0, 0, we, ok, rd, rv);
    do_op(2'b11, 32'h60, 32'h5, 0, 0, 1, 0, we, ok, rd, rv);
    check("R5 irq same cycle as SC", {31'b0, we}, 0);
  endtask

  task automatic t_race();
    do_op(2'b10, 32'h64, 0, 0, 0, 0, 0, we, ok, rd, rv);
    do_op(2'b11, 32'h64, 32'h6, 1, 32'h64, 0, 0, we, ok, rd, rv);
    check("R8 snoop wins write", {31'b0, we}, 0);
    check("R8 snoop wins result", {31'b0, ok}, 0);
  endtask

  task automatic t_replace();
    do_op(2'b10, 32'h70, 0, 0, 0, 0, 0, we, ok, rd, rv);
    do_op(2'b10, 32'h74, 0, 0, 0, 0, 0, we, ok, rd, rv);
    do_op(2'b11, 32'h70, 32'h7, 0, 0, 0, 0, we, ok, rd, rv);
    check("R9 old granule fails", {31'b0, ok}, 0);
    do_op(2'b10, 32'h70, 0, 0, 0, 0, 0, we, ok, rd, rv);
    do_op(2'b10, 32'h74, 0, 0, 0, 0, 0, we, ok, rd, rv);
    do_op(2'b11, 32'h74, 32'h8, 0, 0, 0, 0, we, ok, rd, rv);
    check("R9 new granule succeeds", {31'b0, ok}, 1);
  endtask

  task automatic t_plain();
    do_op(2'b10, 32'h78, 0, 0, 0, 0, 0, we, ok, rd, rv);
    do_op(2'b01, 32'h78, 32'h99, 0, 0, 0, 0, we, ok, rd, rv);
    check("R11 plain store writes", {31'b0, we}, 1);
    do_op(2'b00, 32'h78, 0, 0, 0, 0, 0, we, ok, rd, rv);
    check("R11 plain load data", rd, 32'h99);
    do_op(2'b11, 32'h78, 32'h9A, 0, 0, 0, 0, we, ok, rd, rv);
    check("R11 plain ops keep rsv", {31'b0, ok}, 1);
  endtask

  initial begin
    for (int i = 0; i < 64; i++) mem[i] = 32'h1000 + i;
    repeat (3) @(negedge clk);
    rst_n = 1;
    t_reset();
    t_basic();
    t_granule();
    t_mismatch();
    t_snoop();
    t_kill();
    t_race();
    t_replace();
    t_plain();
    repeat (2) @(negedge clk);
    finish_run();
  end
endmodule